// File: doc/BRIEF.md
# DSP Condition Status Register

This block keeps the condition state of a DSP datapath in one 8-bit status register. After each qualifying DSP data operation it latches the result flags reported by the arithmetic unit. It also derives one selected-condition bit, DC. A 3-bit select field held in the same register chooses which condition DC follows.

DC decides whether a conditional DSP operation may write its result into the DSP register file. The block turns DC and the operation's true/false qualifier into a writeback enable. That enable covers only the DSP register writes. Address-register updates and memory traffic on the CPU side are left to other logic.

The register is also a system register. A store reads it back as a 32-bit word with the upper 24 bits at zero. A load replaces all 8 bits in one cycle.

Top module: `dsp_cond_status`

## Requirements
- R1: While `rst_ni` is low, the register is all zero, so `sr_rdata_o` reads 0.
- R2: The register layout is as follows. Bit 0 is DC. Bits 3:1 are the select field. Bit 4 is zero, bit 5 is negative, bit 6 is overflow and bit 7 is signed greater-than, where greater-than = !zero && (negative == overflow). `sr_rdata_o[31:8]` is always 0.
- R3: A valid, unconditional operation of class 2'b00 (ALU) loads bits 7:4 and DC at the next rising clock edge. The select field keeps its value.
- R4: The select field picks the value loaded into DC. Code 000 gives carry, 001 negative, 010 zero, 011 overflow, 100 signed greater-than, and 101 signed greater-or-equal (negative == overflow).
- R5: Select codes 110 and 111 load DC as 0.
- R6: Operations of class 2'b01 (plain multiply), 2'b10 (X/Y/single data move) and 2'b11 (CPU instruction, including multiply-accumulate) leave the register unchanged.
- R7: A conditional operation (`op_cond_i`=1) leaves the register unchanged, whatever its class.
- R8: `wb_en_o` is 1 for an unconditional operation. For a conditional operation it is 1 exactly when `op_if_true_i` equals the current DC.
- R9: `sr_wr_i` loads `sr_wdata_i[7:0]` into the register at the next edge. This load wins over a flag update in the same cycle.
- R10: While `op_valid_i` is 0 and no system-register write is present, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | A DSP-side operation completes this cycle |
| op_class_i | input | 2 | Operation class: 00 ALU, 01 multiply, 10 move, 11 CPU |
| op_cond_i | input | 1 | The operation is conditional |
| op_if_true_i | input | 1 | Qualifier: 1 = execute if DC set, 0 = execute if DC clear |
| res_carry_i | input | 1 | Result carry/borrow |
| res_neg_i | input | 1 | Result negative |
| res_zero_i | input | 1 | Result zero |
| res_ovf_i | input | 1 | Result overflow |
| sr_wr_i | input | 1 | System-register load |
| sr_wdata_i | input | 32 | System-register load data |
| sr_rdata_o | output | 32 | Register readback, upper bits zero |
| wb_en_o | output | 1 | DSP register-file writeback enable |

## Verification
The bench runs ALU operations through every select code, including the two reserved codes. A design that decodes the select field wrongly, or lets a reserved code through, would put the wrong DC value in the readback.

Multiplies, moves, CPU operations and conditional ALU operations arrive with flag patterns that would change the register if they were allowed to update it. Any leak shows up as a changed readback.

A system-register load is sent in the same cycle as an ALU update. A design with the wrong priority would latch the ALU flags in place of the written byte.

The writeback enable is checked for both qualifier values against both DC states. An inverted compare, or a gate applied to unconditional operations, would then show up at the port.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int unsigned SR_W     = 8;
  localparam int unsigned BUS_W    = 32;
  localparam int unsigned CS_W     = 3;
  localparam int unsigned FLAG_W   = 4;
  localparam int unsigned DC_BIT   = 0;
  localparam int unsigned CS_LO    = 1;
  localparam int unsigned FLAG_LO  = CS_LO + CS_W;

  typedef enum logic [1:0] {
    CLS_ALU  = 2'b00,
    CLS_MUL  = 2'b01,
    CLS_MOVE = 2'b10,
    CLS_CPU  = 2'b11
  } op_class_e;

  typedef enum logic [CS_W-1:0] {
    SEL_CARRY = 3'b000,
    SEL_NEG   = 3'b001,
    SEL_ZERO  = 3'b010,
    SEL_OVF   = 3'b011,
    SEL_GT    = 3'b100,
    SEL_GE    = 3'b101
  } cond_sel_e;

  typedef struct packed {
    logic gt;
    logic ovf;
    logic neg;
    logic zero;
  } flags_t;
endpackage

// File: rtl/dcs_cond_select.sv
module dcs_cond_select
  import dcs_pkg::*;
(
  input  logic [CS_W-1:0] cs_i,
  input  logic            carry_i,
  input  logic            neg_i,
  input  logic            zero_i,
  input  logic            ovf_i,
  output flags_t          flags_o,
  output logic            dc_o
);
  logic ge;
  assign ge = ~(neg_i ^ ovf_i);

  always_comb begin
    flags_o.zero = zero_i;
    flags_o.neg  = neg_i;
    flags_o.ovf  = ovf_i;
    flags_o.gt   = ge & ~zero_i;
  end

  always_comb begin
    unique case (cs_i)
      SEL_CARRY: dc_o = carry_i;
      SEL_NEG:   dc_o = neg_i;
      SEL_ZERO:  dc_o = zero_i;
      SEL_OVF:   dc_o = ovf_i;
      SEL_GT:    dc_o = ge & ~zero_i;
      SEL_GE:    dc_o = ge;
      default:   dc_o = 1'b0;  // reserved codes
    endcase
  end
endmodule

// File: rtl/dcs_update_ctrl.sv
module dcs_update_ctrl
  import dcs_pkg::*;
(
  input  logic       op_valid_i,
  input  logic [1:0] op_class_i,
  input  logic       op_cond_i,
  output logic       upd_o
);
  // only unconditional ALU-class operations touch the flags
  assign upd_o = op_valid_i & ~op_cond_i & (op_class_i == CLS_ALU);
endmodule

// File: rtl/dcs_wb_gate.sv
module dcs_wb_gate (
  input  logic op_cond_i,
  input  logic op_if_true_i,
  input  logic dc_i,
  output logic wb_en_o
);
  assign wb_en_o = op_cond_i ? ~(op_if_true_i ^ dc_i) : 1'b1;
endmodule

// File: rtl/dsp_cond_status.sv
module dsp_cond_status
  import dcs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic [1:0]       op_class_i,
  input  logic             op_cond_i,
  input  logic             op_if_true_i,
  input  logic             res_carry_i,
  input  logic             res_neg_i,
  input  logic             res_zero_i,
  input  logic             res_ovf_i,
  input  logic             sr_wr_i,
  input  logic [BUS_W-1:0] sr_wdata_i,
  output logic [BUS_W-1:0] sr_rdata_o,
  output logic             wb_en_o
);
  localparam int unsigned PAD_W = BUS_W - SR_W;

  logic [SR_W-1:0]  sr_q;
  logic [CS_W-1:0]  cs_q;
  logic             dc_q;
  flags_t           new_flags;
  logic             new_dc;
  logic             upd;

  assign cs_q = sr_q[CS_LO +: CS_W];
  assign dc_q = sr_q[DC_BIT];

  dcs_cond_select u_sel (
    .cs_i    (cs_q),
    .carry_i (res_carry_i),
    .neg_i   (res_neg_i),
    .zero_i  (res_zero_i),
    .ovf_i   (res_ovf_i),
    .flags_o (new_flags),
    .dc_o    (new_dc)
  );

  dcs_update_ctrl u_upd (
    .op_valid_i (op_valid_i),
    .op_class_i (op_class_i),
    .op_cond_i  (op_cond_i),
    .upd_o      (upd)
  );

  dcs_wb_gate u_wb (
    .op_cond_i    (op_cond_i),
    .op_if_true_i (op_if_true_i),
    .dc_i         (dc_q),
    .wb_en_o      (wb_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (sr_wr_i)  sr_q <= sr_wdata_i[SR_W-1:0];  // load wins over update
    else if (upd)      sr_q <= {new_flags, cs_q, new_dc};
  end

  assign sr_rdata_o = {{PAD_W{1'b0}}, sr_q};

  assert_sr_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_wr_i |=> sr_rdata_o[SR_W-1:0] == $past(sr_wdata_i[SR_W-1:0]));

  assert_hold_other_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sr_wr_i && op_valid_i && op_class_i != CLS_ALU) |=> $stable(sr_rdata_o));

  assert_hold_cond_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sr_wr_i && op_cond_i) |=> $stable(sr_rdata_o));

  assert_reserved_dc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sr_wr_i && op_valid_i && !op_cond_i && op_class_i == CLS_ALU && cs_q[2:1] == 2'b11)
    |=> sr_rdata_o[DC_BIT] == 1'b0);

  assert_cs_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sr_wr_i |=> $stable(sr_rdata_o[CS_LO +: CS_W]));

  assert_wb_uncond_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_cond_i |-> wb_en_o);
endmodule

// File: tb/dsp_cond_status_tb.sv
module dsp_cond_status_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [1:0]  op_class_i = 2'b00;
  logic        op_cond_i = 1'b0;
  logic        op_if_true_i = 1'b0;
  logic        res_carry_i = 1'b0, res_neg_i = 1'b0, res_zero_i = 1'b0, res_ovf_i = 1'b0;
  logic        sr_wr_i = 1'b0;
  logic [31:0] sr_wdata_i = '0;
  logic [31:0] sr_rdata_o;
  logic        wb_en_o;

  int total = 0;
  int bad = 0;
  logic [7:0] model = '0;

  typedef struct { logic [31:0] exp; string req; } item_t;
  item_t q[$];

  always #4 clk_i = ~clk_i;

  dsp_cond_status u_dut (.*);

  function automatic logic [7:0] alu_next(logic [7:0] cur, logic c, logic n, logic z, logic v);
    logic ge, gt, dc;
    ge = (n == v);
    gt = ge && !z;
    case (cur[3:1])
      3'd0: dc = c;
      3'd1: dc = n;
      3'd2: dc = z;
      3'd3: dc = v;
      3'd4: dc = gt;
      3'd5: dc = ge;
      default: dc = 1'b0;
    endcase
    return {gt, v, n, z, cur[3:1], dc};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one cycle per call
  task automatic drive(input logic v, input logic [1:0] cls, input logic cond, input logic ift,
                       input logic [3:0] cnzv, input logic wr, input logic [31:0] wd,
                       input string req);
    logic [7:0] nxt;
    @(negedge clk_i);
    op_valid_i = v; op_class_i = cls; op_cond_i = cond; op_if_true_i = ift;
    {res_carry_i, res_neg_i, res_zero_i, res_ovf_i} = cnzv;
    sr_wr_i = wr; sr_wdata_i = wd;
    #1;
    if (v && cond) check({31'b0, wb_en_o}, {31'b0, ift == model[0]}, "R8 cond wb_en");
    if (v && !cond) check({31'b0, wb_en_o}, 32'd1, "R8 uncond wb_en");
    nxt = model;
    if (wr) nxt = wd[7:0];
    else if (v && !cond && cls == 2'b00) nxt = alu_next(model, cnzv[3], cnzv[2], cnzv[1], cnzv[0]);
    model = nxt;
    q.push_back('{exp: {24'b0, nxt}, req: req});
  endtask

  task automatic alu(input logic [3:0] cnzv, input string req);
    drive(1, 2'b00, 0, 0, cnzv, 0, '0, req);
  endtask

  task automatic setsr(input logic [7:0] b, input string req);
    drive(0, 2'b00, 0, 0, 4'h0, 1, {24'hABCDEF, b}, req);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(sr_rdata_o, it.exp, it.req);
    end
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    check(sr_rdata_o, 32'd0, "R1 reset");
    repeat (3) @(posedge clk_i);
    #1 check(sr_rdata_o, 32'd0, "R1 reset held");
    @(negedge clk_i); rst_ni = 1'b1;

    // select field sweep, R4 and R5
    for (int cs = 0; cs < 8; cs++) begin
      setsr(8'(cs << 1), "R9 load cs");
      for (int p = 0; p < 16; p++) alu(4'(p), (cs >= 6) ? "R5 reserved dc" : "R4 select/R3 R2 update");
    end

    // other classes and idle, R6 and R10
    setsr(8'h0A, "R9 load");
    alu(4'b0110, "R3 update");
    for (int c = 1; c < 4; c++) drive(1, 2'(c), 0, 0, 4'b1001, 0, '0, "R6 class hold");
    drive(0, 2'b00, 0, 0, 4'b1001, 0, '0, "R10 idle hold");

    // conditional ops, R7 and R8, both DC states
    setsr(8'h01, "R9 dc=1");
    drive(1, 2'b00, 1, 1, 4'b1111, 0, '0, "R7 cond hold");
    drive(1, 2'b00, 1, 0, 4'b0000, 0, '0, "R7 cond hold");
    setsr(8'h00, "R9 dc=0");
    drive(1, 2'b00, 1, 1, 4'b1111, 0, '0, "R7 cond hold");
    drive(1, 2'b01, 1, 0, 4'b1111, 0, '0, "R7 cond hold");

    // priority R9
    setsr(8'h02, "R9 load");
    drive(1, 2'b00, 0, 0, 4'b1111, 1, 32'hFFFF_FF5C, "R9 priority over update");
    alu(4'b0010, "R3 after load");

    drive(0, 2'b00, 0, 0, 4'h0, 0, '0, "R10 idle");
    @(negedge clk_i);
    @(negedge clk_i);
    check({31'b0, q.size() == 0}, 32'd1, "R2 scoreboard drained");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule